// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked on-chip request port and an external 32K x 8 asynchronous static RAM. The RAM uses one bidirectional byte bus for both directions. A single-word request comes in with an address, a direction flag and, for stores, a data byte. The controller turns it into an active-low strobe sequence on chip enable, output enable and write enable. Each phase of that sequence lasts a whole number of clock cycles. The cycle counts are worked out at elaboration time from the RAM's minimum analog timings, for the chosen speed grade and clock period.

The request side follows valid/ready rules. `req_ready` is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Once a request is taken, `req_ready` stays low until the access has finished, so a requester that keeps `req_valid` high is held off. The request fields are copied into the controller when the request is taken. Read data comes back as a one-cycle `rsp_valid` pulse. The response path has no back-pressure.

On the memory side, the RAM's data pins are modelled as a separate input bus, an output bus and a drive-enable line. The controller turns on its drivers only after the RAM's own outputs have had time to float.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: `req_ready` is high exactly when the controller is idle. A request is taken on an edge where `req_valid` and `req_ready` are both high, and `req_ready` is low in the cycle after that edge.
- R2: A read holds chip enable low, output enable low and write enable high for exactly NRD consecutive cycles, with the address unchanged. NRD is the larger of ceil(tRC/P) and ceil(tOE/P), and at least 1. For the fast grade tRC is 55 ns and tOE is 30 ns. For the slow grade they are 70 ns and 35 ns.
- R3: Read data is sampled from `mem_dq_in` at the edge that ends the last read-window cycle. It appears on `rsp_rdata` with `rsp_valid` high for exactly one cycle, which begins NRD cycles after the acceptance edge.
- R4: A write holds write enable low for exactly NWP consecutive cycles, with chip enable low and output enable high. NWP is the largest of ceil(tWP/P), ceil(tAW/P), ceil(tDW/P) and ceil(tWC/P)-1, and at least 1. The fast grade uses tWP=40, tAW=50, tDW=25 and tWC=55 ns. The slow grade uses 50, 60, 30 and 70 ns.
- R5: `mem_dq_oe` is high in every cycle where write enable is low and in the one cycle after it rises. Chip enable stays low in that extra cycle. Address and write data stay unchanged from the first write-enable-low cycle through the extra cycle. The RAM stores the byte at the rising edge of write enable.
- R6: `mem_dq_oe` is never high while the RAM may drive the bus, meaning chip enable low, output enable low and write enable high. After such a cycle, at least NHZ = ceil(tHZ/P) cycles pass before `mem_dq_oe` rises. tHZ is 20 ns for the fast grade and 25 ns for the slow grade.
- R7: After reset, and whenever the controller is idle, all three strobes are high, `mem_dq_oe` is low, `rsp_valid` is low and `req_ready` is high.
- R8: A write produces no `rsp_valid` pulse.
- R9: Changes on `req_addr`, `req_wdata` and `req_write` after acceptance do not affect the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Byte to store |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | DATA_W | Byte read |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_addr | output | ADDR_W | RAM address |
| mem_dq_out | output | DATA_W | Byte driven toward the RAM |
| mem_dq_oe | output | 1 | Enable for the data-bus drivers |
| mem_dq_in | input | DATA_W | Byte seen on the RAM data pins |

## Verification
The bench builds the fast grade with a 5 ns clock period. This gives an 11-cycle read window, a 10-cycle write pulse and a 4-cycle float gap. These windows are long enough that being one cycle short in any phase shows up in the RAM model's data: the model returns a junk byte until the access time has passed, and it latches data only at the rising edge of write enable. The slow-grade counts come from the same formulas, but this bench does not build that variant. Random mixes of reads and writes produce read-after-write turnarounds at many spacings, and scrambling the request fields while the controller is busy exercises the capture at acceptance.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD       = 3'd1,
    ST_WR_WAIT  = 3'd2,
    ST_WR_PULSE = 3'd3,
    ST_WR_HOLD  = 3'd4
  } ctrl_state_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // ceiling of ns / period, never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned rd_window_cycles(input bit slow, input int unsigned per);
    int unsigned t_cyc, t_oe;
    t_cyc = slow ? 70 : 55;
    t_oe  = slow ? 35 : 30;
    return umax(ns_to_cyc(t_cyc, per), ns_to_cyc(t_oe, per));
  endfunction

  function automatic int unsigned wr_pulse_cycles(input bit slow, input int unsigned per);
    int unsigned t_wp, t_aw, t_dw, t_cyc, n;
    t_wp  = slow ? 50 : 40;
    t_aw  = slow ? 60 : 50;
    t_dw  = slow ? 30 : 25;
    t_cyc = slow ? 70 : 55;
    n = umax(umax(ns_to_cyc(t_wp, per), ns_to_cyc(t_aw, per)),
             umax(ns_to_cyc(t_dw, per), ns_to_cyc(t_cyc, per) - 1));
    return (n == 0) ? 1 : n;
  endfunction

  function automatic int unsigned float_cycles(input bit slow, input int unsigned per);
    return ns_to_cyc(slow ? 25 : 20, per);
  endfunction

endpackage

// File: rtl/sram_cycle_counter.sv
`timescale 1ns/1ps
module sram_cycle_counter #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            count <= '0;
    else if (load)         count <= load_val;
    else if (count != '0)  count <= count - 1'b1;
  end
endmodule

// File: rtl/sram_dq_path.sv
`timescale 1ns/1ps
module sram_dq_path #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_load,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_out   <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_load) dq_out <= wr_data;
      if (cap_en)  rd_data <= dq_in;
      rd_valid <= cap_en;
    end
  end
endmodule

// File: rtl/sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 15,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 5,
  parameter bit          SLOW_GRADE    = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int unsigned N_RD = rd_window_cycles(SLOW_GRADE, CLK_PERIOD_NS);
  localparam int unsigned N_WP = wr_pulse_cycles(SLOW_GRADE, CLK_PERIOD_NS);
  localparam int unsigned N_HZ = float_cycles(SLOW_GRADE, CLK_PERIOD_NS);
  localparam int unsigned PH_W = $clog2(umax(N_RD, N_WP) + 1);
  localparam int unsigned HZ_W = $clog2(N_HZ + 1);

  ctrl_state_e       state_q, state_d;
  logic              accept, ph_load, rd_done;
  logic [PH_W-1:0]   ph_val, ph_count;
  logic [HZ_W-1:0]   hz_count;
  logic              ph_zero, hz_le1;
  logic [ADDR_W-1:0] addr_q;

  assign ph_zero   = (ph_count == '0);
  assign hz_le1    = (hz_count <= HZ_W'(1));
  assign req_ready = (state_q == ST_IDLE);
  assign mem_addr  = addr_q;

  sram_cycle_counter #(.W(PH_W)) u_phase_cnt (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .count(ph_count)
  );

  sram_cycle_counter #(.W(HZ_W)) u_float_cnt (
    .clk(clk), .rst_n(rst_n), .load(rd_done), .load_val(HZ_W'(N_HZ)), .count(hz_count)
  );

  sram_dq_path #(.DATA_W(DATA_W)) u_dq (
    .clk(clk), .rst_n(rst_n),
    .wr_load(accept && req_write), .wr_data(req_wdata),
    .cap_en(rd_done), .dq_in(mem_dq_in),
    .dq_out(mem_dq_out), .rd_data(rsp_rdata), .rd_valid(rsp_valid)
  );

  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    ph_load = 1'b0;
    ph_val  = '0;
    rd_done = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        accept = 1'b1;
        if (!req_write) begin
          state_d = ST_RD;
          ph_load = 1'b1;
          ph_val  = PH_W'(N_RD - 1);
        end else if (hz_le1) begin
          state_d = ST_WR_PULSE;
          ph_load = 1'b1;
          ph_val  = PH_W'(N_WP - 1);
        end else begin
          state_d = ST_WR_WAIT;
        end
      end
      ST_RD: if (ph_zero) begin
        state_d = ST_IDLE;
        rd_done = 1'b1;
      end
      ST_WR_WAIT: if (hz_le1) begin
        state_d = ST_WR_PULSE;
        ph_load = 1'b1;
        ph_val  = PH_W'(N_WP - 1);
      end
      ST_WR_PULSE: if (ph_zero) state_d = ST_WR_HOLD;
      ST_WR_HOLD:  state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  // strobes registered from the next state so the pins never glitch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      state_q   <= state_d;
      if (accept) addr_q <= req_addr;
      mem_ce_n  <= !(state_d == ST_RD || state_d == ST_WR_PULSE || state_d == ST_WR_HOLD);
      mem_oe_n  <= !(state_d == ST_RD);
      mem_we_n  <= !(state_d == ST_WR_PULSE);
      mem_dq_oe <= (state_d == ST_WR_PULSE || state_d == ST_WR_HOLD);
    end
  end
endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 15,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 5,
  parameter bit          SLOW_GRADE    = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              req_write,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe,
  input logic [DATA_W-1:0] mem_dq_in
);
  localparam int unsigned N_HZ = float_cycles(SLOW_GRADE, CLK_PERIOD_NS);

  logic ram_drives;
  int unsigned quiet_q;
  assign ram_drives = !mem_ce_n && !mem_oe_n && mem_we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          quiet_q <= N_HZ;
    else if (ram_drives) quiet_q <= 0;
    else if (quiet_q < N_HZ) quiet_q <= quiet_q + 1;
  end

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R1
  AST_READY_MEANS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe)); // R7
  AST_READ_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_drives && $past(ram_drives)) |-> $stable(mem_addr)); // R2
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R3
  AST_WE_LOW_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe && !mem_ce_n && mem_oe_n)); // R4
  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n && $stable(mem_addr) && $stable(mem_dq_out))); // R5
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && ram_drives)); // R6
  AST_FLOAT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (quiet_q >= N_HZ)); // R6
endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .CLK_PERIOD_NS(CLK_PERIOD_NS), .SLOW_GRADE(SLOW_GRADE)
) u_chk (.*);

// File: tb/test_sram_strobe_ctrl.sv
`timescale 1ns/1ps
module test_sram_strobe_ctrl;
  localparam int unsigned P = 5;

  function automatic int unsigned cdiv(input int unsigned ns);
    int unsigned c;
    c = (ns + P - 1) / P;
    return (c == 0) ? 1 : c;
  endfunction
  function automatic int unsigned mx(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  localparam int unsigned EXP_RD = mx(cdiv(55), cdiv(30));
  localparam int unsigned EXP_WP = mx(mx(cdiv(40), cdiv(50)), mx(cdiv(25), cdiv(55) - 1));
  localparam int unsigned EXP_HZ = cdiv(20);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  rsp_rdata, mem_dq_out, mem_dq_in;
  logic [14:0] mem_addr;

  always #2.5 clk = ~clk;

  sram_strobe_ctrl #(.CLK_PERIOD_NS(P), .SLOW_GRADE(1'b0)) i_sram_strobe_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- RAM model ----------------
  logic [7:0] model  [int unsigned];
  logic [7:0] shadow [int unsigned];
  logic       drv;
  int unsigned rdlow = 0, welow = 0, quiet = 1000;
  logic [14:0] rd_addr_q = '0, w_addr = '0;
  logic [7:0]  w_data = '0, rd_word = '0;
  logic        we_prev = 1'b1, oe_prev = 1'b0;

  assign drv = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_dq_in = (drv && rdlow >= EXP_RD) ? rd_word : 8'hEE;

  always @(negedge clk) if (rst_n) begin
    if (rdlow > 0 && !drv) chk(rdlow == EXP_RD, "R2", "read window length", rdlow, EXP_RD);
    if (drv && rdlow > 0 && mem_addr != rd_addr_q) chk(1'b0, "R2", "address moved", mem_addr, rd_addr_q);
    rdlow     <= drv ? rdlow + 1 : 0;
    rd_addr_q <= mem_addr;
    rd_word   <= model.exists(int'(mem_addr)) ? model[int'(mem_addr)] : 8'h00;

    if (!mem_we_n) begin
      if (we_prev) begin
        w_addr <= mem_addr;
        w_data <= mem_dq_out;
      end else if (mem_addr != w_addr || mem_dq_out != w_data)
        chk(1'b0, "R5", "write data moved", mem_dq_out, w_data);
      if (!mem_dq_oe || mem_ce_n || !mem_oe_n)
        chk(1'b0, "R4", "strobe shape", {mem_dq_oe, mem_ce_n, mem_oe_n}, 3'b101);
    end
    if (!we_prev && mem_we_n) begin
      chk(welow == EXP_WP, "R4", "write pulse length", welow, EXP_WP);
      chk(mem_dq_oe && !mem_ce_n && mem_addr == w_addr && mem_dq_out == w_data,
          "R5", "hold cycle", mem_dq_out, w_data);
      if (mem_dq_oe && !mem_ce_n) model[int'(mem_addr)] = mem_dq_out;
    end
    welow   <= !mem_we_n ? welow + 1 : 0;
    we_prev <= mem_we_n;

    if (mem_dq_oe && !oe_prev) chk(quiet >= EXP_HZ, "R6", "float gap", quiet, EXP_HZ);
    if (mem_dq_oe && drv) chk(1'b0, "R6", "bus contention", 1, 0);
    quiet   <= drv ? 0 : (quiet < 1000 ? quiet + 1 : quiet);
    oe_prev <= mem_dq_oe;
  end

  // ---------------- driver ----------------
  task automatic issue(input bit wr, input logic [14:0] a, input logic [7:0] d);
    int n;
    bit seen;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;              // R9: scramble fields while busy
    req_write = 1'($urandom);
    req_addr  = 15'($urandom);
    req_wdata = 8'($urandom);
    chk(!req_ready, "R1", "ready after accept", req_ready, 0);
    n = 0;
    if (!wr) begin
      while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
      chk(n == EXP_RD, "R3", "read latency", n, EXP_RD);
      chk(rsp_rdata == shadow[int'(a)], "R3", "read data (R9 capture)", rsp_rdata, shadow[int'(a)]);
      @(negedge clk);
      chk(!rsp_valid, "R3", "single pulse", rsp_valid, 0);
    end else begin
      seen = 0;
      while (!req_ready && n < 100) begin
        if (rsp_valid) seen = 1;
        @(negedge clk); n++;
      end
      if (rsp_valid) seen = 1;
      chk(!seen, "R8", "no response to write", seen, 0);
      shadow[int'(a)] = d;
    end
  endtask

  function automatic logic [14:0] pick_addr(input int unsigned idx);
    return 15'((idx * 517) ^ 15'h2A5A);
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid && req_ready,
        "R7", "reset state", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid, req_ready}, 6'b111001);
    rst_n = 1'b1;

    issue(1'b1, 15'h0000, 8'hA5);
    issue(1'b1, 15'h7FFF, 8'h5A);
    issue(1'b0, 15'h0000, 8'h00);
    issue(1'b0, 15'h7FFF, 8'h00);
    issue(1'b1, 15'h0000, 8'hC3);       // read then write at once: R6 gap
    issue(1'b0, 15'h0000, 8'h00);       // write then read same word
    issue(1'b1, 15'h1234, 8'hFF);
    issue(1'b1, 15'h1234, 8'h00);       // back-to-back writes
    issue(1'b0, 15'h1234, 8'h00);

    void'($urandom(32'h5EED));
    for (int i = 0; i < 300; i++) begin
      logic [14:0] a;
      bit wr;
      a  = pick_addr($urandom % 64);
      wr = ($urandom % 2 == 1) || !shadow.exists(int'(a));
      issue(wr, a, 8'($urandom));
    end

    @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready,
        "R7", "idle after traffic", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}, 5'b11101);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R1 watchdog: actual hung expected idle");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule